// File: doc/BRIEF.md
# Streaming Unsharp-Mask Sharpener

This block sharpens an 8-bit greyscale image that arrives as a raster-order pixel stream. A first stencil stage sums each pixel with its left and right neighbours. A second stencil stage sums three of those horizontal results, taken from the rows above, at and below the pixel. That stage then takes the difference between a delay-aligned copy of the raw pixel and the resulting 3x3 box blur, scales it by a gain (0.1 by default) and adds it back to the pixel. The raw pixel therefore reaches the second stage by a bypass path next to the blur path, so the data flow is a small DAG.

Image width and height are parameters. Pixels outside the image are replaced by the nearest edge pixel. Both ends are valid/ready streams. A pixel moves when valid and ready are both high on a rising clock edge. Once the sender raises `in_valid` it holds the pixel until it is accepted. `in_ready` depends combinationally on `out_ready`. While an output pixel is held back by `out_ready` low, the block accepts no input. The first output appears after one line plus two pixels of input. The bottom row can only be finished once the frame is complete, so after the last input pixel of a frame the block runs IMG_W+1 internal flush steps. During these steps `in_ready` stays low and the remaining outputs are drained.

Top module: `unsharp_stream`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, and `out_data`, `out_eol` and `out_eof` stay unchanged until the pixel is taken.
- R3: The horizontal sum for pixel (x,y) is p(x-1,y)+p(x,y)+p(x+1,y). A column outside 0..IMG_W-1 is clamped to the nearest edge column.
- R4: The vertical sum is h(x,y-1)+h(x,y)+h(x,y+1) of the horizontal sums, written s. A row outside 0..IMG_H-1 is clamped to the nearest edge row.
- R5: With k = 9*p(x,y) - s, the output is p + floor((k*728 + 32768) / 65536), saturated to 0..255. The constant 728 is gain 10/100 divided by 9 with 16 fractional bits.
- R6: Exactly one output pixel is produced per input pixel, in raster order. `out_eol` is 1 on the last pixel of each row, and `out_eof` is 1 only on the last pixel of the frame.
- R7: After the last input pixel of a frame is accepted, `in_ready` is 0 on the next cycle. With `out_ready` held high, the last output is presented IMG_W+2 cycles after that acceptance, with no further input.
- R8: A frame of constant value v produces v at every output pixel.
- R9: Frames may follow each other back to back without reset. Each frame is filtered independently, with its own top and bottom clamping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block accepts the input pixel this cycle |
| in_data | input | 8 | Input pixel, raster order |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_data | output | 8 | Sharpened pixel |
| out_eol | output | 1 | Output pixel is last of its row |
| out_eof | output | 1 | Output pixel is last of the frame |

## Verification
The filter is driven with several images, each of which exposes a different kind of error:
- A flat frame must pass through unchanged, which exposes bias in the rounding or the scale.
- A two-way ramp separates a wrong horizontal or vertical sum.
- Lone bright corner pixels show whether the edge clamping picks the right neighbour in all four directions.
- A 0/255 checkerboard drives the result past both saturation limits.

A pseudo-random frame is run with gaps on both `in_valid` and `out_ready`, which tests stall holding and back-pressure without changing results. Two distinct frames run back to back show that no rows leak from one frame into the next.

// File: rtl/us_pkg.sv
package us_pkg;
  localparam int PIX_W = 8;
  typedef logic [PIX_W-1:0] pix_t;

  function automatic pix_t sat_pix(input logic signed [31:0] v);
    if (v < 0) return '0;
    else if (v > (2**PIX_W) - 1) return '1;
    else return v[PIX_W-1:0];
  endfunction
endpackage

// File: rtl/us_sequencer.sv
module us_sequencer #(
  parameter int IMG_W = 16,
  parameter int IMG_H = 8,
  localparam int CW = $clog2(IMG_W),
  localparam int RW = $clog2(IMG_H + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          out_free,
  output logic          tick,
  output logic          in_ready,
  output logic          flushing,
  output logic          hv,
  output logic [CW-1:0] icol,
  output logic [CW-1:0] hcol,
  output logic [RW-1:0] hrow
);
  localparam logic [CW-1:0] LAST_COL = CW'(IMG_W - 1);
  localparam logic [RW-1:0] ROW_H    = RW'(IMG_H);
  localparam logic [RW-1:0] ROW_END  = RW'(IMG_H + 1);

  logic [RW-1:0] irow;

  // rows IMG_H and IMG_H+1 are virtual: they drain the bottom border
  assign flushing = (irow >= ROW_H);
  assign in_ready = out_free && !flushing;
  assign tick     = out_free && (flushing || in_valid);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      icol <= '0;
      irow <= '0;
      hcol <= '0;
      hrow <= '0;
      hv   <= 1'b0;
    end else if (tick) begin
      if (irow == ROW_END) begin
        icol <= '0;
        irow <= '0;
        hv   <= 1'b0;
      end else begin
        hcol <= icol;
        hrow <= irow;
        hv   <= 1'b1;
        if (icol == LAST_COL) begin
          icol <= '0;
          irow <= irow + 1'b1;
        end else begin
          icol <= icol + 1'b1;
        end
      end
    end
  end

  // R7: the flush phase is entered only by consuming a pixel
  a_r7_flush_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flushing) |-> $past(tick));

  // R6: columns wrap after the last column of a row
  a_r6_col_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && icol == LAST_COL) |=> (icol == '0));
endmodule

// File: rtl/us_hsum.sv
module us_hsum
  import us_pkg::*;
#(
  parameter int IMG_W = 16,
  localparam int CW = $clog2(IMG_W)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  pix_t           px,
  input  logic [CW-1:0]  icol,
  output logic [PIX_W+1:0] hs,
  output pix_t           ctr
);
  pix_t r1, r2;
  pix_t lft, mid, rgt;

  // the sum is for the position one step behind the arriving pixel
  always_comb begin
    if (icol == '0) begin
      // previous position is the last column: clamp the right neighbour
      lft = r2; mid = r1; rgt = r1;
    end else if (icol == CW'(1)) begin
      // previous position is column 0: clamp the left neighbour
      lft = r1; mid = r1; rgt = px;
    end else begin
      lft = r2; mid = r1; rgt = px;
    end
    hs  = {2'b00, lft} + {2'b00, mid} + {2'b00, rgt};
    ctr = r1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r1 <= '0;
      r2 <= '0;
    end else if (tick) begin
      r1 <= px;
      r2 <= r1;
    end
  end
endmodule

// File: rtl/us_linebuf.sv
module us_linebuf #(
  parameter int DW    = 10,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  // read returns the value written one line earlier at this column
  assign rdata = mem[addr];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end
endmodule

// File: rtl/us_vsharp.sv
module us_vsharp
  import us_pkg::*;
#(
  parameter int IMG_W    = 16,
  parameter int IMG_H    = 8,
  parameter int GAIN_PCT = 10,
  parameter int FRAC     = 16,
  localparam int CW  = $clog2(IMG_W),
  localparam int RW  = $clog2(IMG_H + 2),
  localparam int HSW = PIX_W + 2,
  localparam int SSW = PIX_W + 4
) (
  input  logic           clk,
  input  logic           tick,
  input  logic           hv,
  input  logic [CW-1:0]  hcol,
  input  logic [RW-1:0]  hrow,
  input  logic [HSW-1:0] hs,
  input  pix_t           ctr,
  output logic           produce,
  output pix_t           y,
  output logic           eol,
  output logic           eof
);
  // gain/100 divided by 9, rounded, in FRAC fractional bits
  localparam int KQ  = (GAIN_PCT * (1 << FRAC) + 450) / 900;
  localparam int RND = 1 << (FRAC - 1);
  localparam int NLB = 2;

  logic           we;
  logic [HSW-1:0] lb_wr [NLB];
  logic [HSW-1:0] lb_rd [NLB];
  pix_t           p;

  assign we = tick && hv;

  // chain of line buffers for horizontal sums: one and two rows back
  for (genvar i = 0; i < NLB; i++) begin : g_hlb
    if (i == 0) begin : g_head
      assign lb_wr[i] = hs;
    end else begin : g_tail
      assign lb_wr[i] = lb_rd[i-1];
    end
    us_linebuf #(.DW(HSW), .DEPTH(IMG_W)) u_lb (
      .clk(clk), .we(we), .addr(hcol), .wdata(lb_wr[i]), .rdata(lb_rd[i]));
  end

  // raw bypass, delayed by one line to meet the blur of the same pixel
  us_linebuf #(.DW(PIX_W), .DEPTH(IMG_W)) u_raw (
    .clk(clk), .we(we), .addr(hcol), .wdata(ctr), .rdata(p));

  logic [HSW-1:0] up, dn, md;
  logic [SSW-1:0] s9;
  logic signed [31:0] k_s, prod_s, dl_s, y_s;

  always_comb begin
    md = lb_rd[0];
    up = (hrow == RW'(1)) ? md : lb_rd[1];
    dn = (hrow == RW'(IMG_H)) ? md : hs;
    s9 = {2'b00, up} + {2'b00, md} + {2'b00, dn};
    k_s    = $signed(32'(p)) * 9 - $signed(32'(s9));
    prod_s = k_s * KQ + RND;
    dl_s   = prod_s >>> FRAC;
    y_s    = $signed(32'(p)) + dl_s;
    y      = sat_pix(y_s);
  end

  assign produce = hv && (hrow != '0);
  assign eol     = (hcol == CW'(IMG_W - 1));
  assign eof     = eol && (hrow == RW'(IMG_H));
endmodule

// File: rtl/unsharp_stream.sv
module unsharp_stream
  import us_pkg::*;
#(
  parameter int IMG_W    = 16,
  parameter int IMG_H    = 8,
  parameter int GAIN_PCT = 10,
  parameter int FRAC     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_data,
  output logic             out_eol,
  output logic             out_eof
);
  localparam int CW = $clog2(IMG_W);
  localparam int RW = $clog2(IMG_H + 2);

  logic             out_free, tick, flushing, hv;
  logic [CW-1:0]    icol, hcol;
  logic [RW-1:0]    hrow;
  pix_t             px, ctr, y;
  logic [PIX_W+1:0] hs;
  logic             produce, eol, eof;

  assign out_free = !out_valid || out_ready;
  assign px       = flushing ? '0 : in_data;

  us_sequencer #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_free(out_free),
    .tick(tick), .in_ready(in_ready), .flushing(flushing), .hv(hv),
    .icol(icol), .hcol(hcol), .hrow(hrow));

  us_hsum #(.IMG_W(IMG_W)) u_hsum (
    .clk(clk), .rst_n(rst_n), .tick(tick), .px(px), .icol(icol),
    .hs(hs), .ctr(ctr));

  us_vsharp #(.IMG_W(IMG_W), .IMG_H(IMG_H), .GAIN_PCT(GAIN_PCT), .FRAC(FRAC)) u_vs (
    .clk(clk), .tick(tick), .hv(hv), .hcol(hcol), .hrow(hrow), .hs(hs),
    .ctr(ctr), .produce(produce), .y(y), .eol(eol), .eof(eof));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_eol   <= 1'b0;
      out_eof   <= 1'b0;
    end else if (tick) begin
      out_valid <= produce;
      out_data  <= y;
      out_eol   <= eol;
      out_eof   <= eof;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R2: a stalled output pixel is held unchanged
  a_r2_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                   && $stable(out_eol) && $stable(out_eof)));

  // R2: no input is taken while the output is blocked
  a_r2_block_input: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R6: frame end always coincides with a row end
  a_r6_eof_is_eol: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_eof) |-> out_eol);
endmodule

// File: tb/unsharp_stream_test.sv
module unsharp_stream_test;
  localparam int BW = 5;
  localparam int BH = 4;
  localparam int N  = BW * BH;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       out_ready = 1'b1;
  logic       in_ready, out_valid, out_eol, out_eof;
  logic [7:0] out_data;

  int nchk = 0;
  int nfail = 0;
  int img [N];

  always #5 clk = ~clk;

  unsharp_stream #(.IMG_W(BW), .IMG_H(BH)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_eol(out_eol), .out_eof(out_eof));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int pxl(int x, int y);
    int cx = (x < 0) ? 0 : ((x > BW-1) ? BW-1 : x);
    int cy = (y < 0) ? 0 : ((y > BH-1) ? BH-1 : y);
    return img[cy*BW + cx];
  endfunction

  function automatic int hsm(int x, int y);
    return pxl(x-1, y) + pxl(x, y) + pxl(x+1, y);
  endfunction

  function automatic int expect_pix(int x, int y);
    int yu = (y == 0) ? 0 : y - 1;
    int yd = (y == BH-1) ? BH-1 : y + 1;
    int s  = hsm(x, yu) + hsm(x, y) + hsm(x, yd);
    int k  = 9 * pxl(x, y) - s;
    int d  = (k * 728 + 32768) >>> 16;
    int v  = pxl(x, y) + d;
    if (v < 0) v = 0;
    if (v > 255) v = 255;
    return v;
  endfunction

  // stream one frame in img through the block and check every output
  task automatic run_frame(input string tag, input int in_mod, input int out_mod,
                           input bit chk_flush);
    int idx = 0, oidx = 0, cyc = 0, last_in = -1;
    bit pend = 0, held = 0;
    logic [7:0] hdat = '0;
    while (oidx < N && cyc < 5000) begin
      @(negedge clk);
      out_ready = !(out_mod > 0 && (cyc % out_mod) == out_mod - 1);
      if (idx < N && (pend || in_mod == 0 || (cyc % in_mod) != 0)) begin
        in_valid = 1'b1;
        in_data  = 8'(img[idx]);
      end else begin
        in_valid = 1'b0;
      end
      #1;
      if (held) chk(out_valid && out_data == hdat, "R2", "held pixel", int'(out_data), int'(hdat));
      if (out_valid && !out_ready) chk(!in_ready, "R2", "in_ready under stall", int'(in_ready), 0);
      held = out_valid && !out_ready;
      hdat = out_data;
      if (chk_flush && last_in >= 0 && cyc == last_in + 1)
        chk(!in_ready, "R7", "in_ready after last pixel", int'(in_ready), 0);
      if (out_valid && out_ready) begin
        int x = oidx % BW;
        int y = oidx / BW;
        chk(int'(out_data) == expect_pix(x, y), tag, $sformatf("pixel (%0d,%0d)", x, y),
            int'(out_data), expect_pix(x, y));
        chk(out_eol == (x == BW-1), "R6", "out_eol", int'(out_eol), int'(x == BW-1));
        chk(out_eof == (oidx == N-1), "R6", "out_eof", int'(out_eof), int'(oidx == N-1));
        if (chk_flush && oidx == N-1)
          chk(cyc - last_in == BW + 2, "R7", "flush latency", cyc - last_in, BW + 2);
        oidx++;
      end
      pend = in_valid && !in_ready;
      if (in_valid && in_ready) begin
        idx++;
        if (idx == N) last_in = cyc;
      end
      cyc++;
    end
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b1;
    chk(oidx == N, "R7", "outputs per frame", oidx, N);
  endtask

  task automatic t_reset;
    #1;
    chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_flat;
    for (int i = 0; i < N; i++) img[i] = 100;
    run_frame("R8", 0, 0, 1'b1);
  endtask

  task automatic t_ramp;
    for (int i = 0; i < N; i++) img[i] = (i % BW) * 40 + (i / BW) * 10;
    run_frame("R3", 0, 0, 1'b0);
  endtask

  task automatic t_corners;
    for (int i = 0; i < N; i++) img[i] = 0;
    img[0] = 200;
    img[N-1] = 90;
    img[BW-1] = 60;
    run_frame("R4", 0, 0, 1'b0);
  endtask

  task automatic t_checker;
    for (int i = 0; i < N; i++) img[i] = (((i % BW) + (i / BW)) % 2 == 1) ? 255 : 0;
    run_frame("R5", 0, 0, 1'b0);
  endtask

  task automatic t_stall;
    for (int i = 0; i < N; i++) img[i] = (i * 73 + 11) % 256;
    run_frame("R2", 3, 4, 1'b0);
  endtask

  task automatic t_frames;
    for (int i = 0; i < N; i++) img[i] = (i * 29) % 256;
    run_frame("R9", 0, 0, 1'b0);
    for (int i = 0; i < N; i++) img[i] = 255 - (i * 17) % 256;
    run_frame("R9", 0, 3, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_flat();
    t_ramp();
    t_corners();
    t_checker();
    t_stall();
    t_frames();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule